// File: doc/BRIEF.md
# Privileged CSR Write Legalizer

This block holds the machine-level status, interrupt-pending, interrupt-enable, interrupt and exception delegation, ISA and trap-vector registers of a processor hart. Every write is legalized before it is stored. Write data is merged through a per-register writable mask. An illegal previous-privilege value is coerced to a legal one. The summary dirty bit is recomputed from the floating-point and extension state fields. The XLEN fields are pinned to the hart's maximum XLEN. The supervisor-level status, pending and enable registers have no storage of their own. They are masked views of the machine registers, and writes to them are routed back into those registers.

The core drives a 12-bit CSR address, write data and a write strobe. Read data for that address is combinational. A write takes effect at the next rising clock edge. Addresses outside the implemented set read as zero, raise an illegal-access flag and ignore writes. When a write changes one of the fields that govern address translation, the block raises a one-cycle flush request. The core uses it to drop cached translations.

Top module: `csr_legalizer`

## Requirements
- R1: After synchronous reset the pending, enable, both delegation and both trap-vector registers read 0. The ISA register reads the MXL code in its top two bits (2 for XLEN=64, 1 for XLEN=32) plus the I, M, A, F, D, C extension bits (bits 8, 12, 0, 5, 3, 2), with S (bit 18) and U (bit 20) set when those modes are supported. Machine status reads 0 apart from its pinned XLEN fields.
- R2: A write to machine status (0x300) changes only SIE[1], MIE[3], SPIE[5], MPIE[7], FS[14:13], MPRV[17], SUM[18], MXR[19], TVM[20], TW[21] and TSR[22]. XS[16:15] is writable only when the extension parameter is set. SPP[8] and every other bit keep their value.
- R3: The MPP field [12:11] stores the legalized written value. It becomes 3 (machine) when user mode is unsupported. Otherwise it becomes 0 (user) when the value is 2 or supervisor mode is unsupported. Otherwise it stores the written value.
- R4: Status bit XLEN-1 is 1 exactly when FS or XS equals 2'b11.
- R5: For XLEN=64, UXL[33:32] and SXL[35:34] always read 2, whatever is written.
- R6: A write that changes MPP, MPRV, SUM or MXR raises the flush output for exactly the one cycle after the write edge. Any other write leaves the output low.
- R7: Pending (0x344) accepts only bits 1 and 5. Enable (0x304) accepts only bits 1, 3, 5, 7, 9 and 12. Interrupt delegation (0x303) accepts only bits 1, 5, 9 and 12.
- R8: Exception delegation (0x302) accepts only bits 0, 3, 8, 12, 13 and 15.
- R9: Supervisor status (0x100) reads machine status masked to bits 1, 5, 8, 13-16, 18 and, for XLEN=64, 33:32, with bit XLEN-1 added. A write to it can reach only bits 1, 5, 8, 13-16, 18 and 19, and the machine status rules then apply.
- R10: Supervisor pending (0x144) and enable (0x104) read the machine register ANDed with interrupt delegation. A supervisor enable write changes only delegated bits. A supervisor pending write changes only bit 1, and only when bit 1 is delegated.
- R11: The supervisor trap vector (0x105) stores the written value with bits 1:0 cleared. The machine trap vector (0x305) stores it with bit 1 cleared.
- R12: In the ISA register (0x301) only bits M[12], A[0], F[5], D[3] and C[2] change on a write. A write with bit 5 clear also clears bit 3.
- R13: Any other address reads 0, drives the illegal flag high and leaves all registers unchanged when written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_addr | input | 12 | CSR address for read and write |
| csr_wdata | input | XLEN | Write data |
| csr_we | input | 1 | Write strobe, sampled at the rising edge |
| csr_rdata | output | XLEN | Combinational read data for csr_addr |
| csr_illegal | output | 1 | High when csr_addr is not an implemented register |
| xlat_flush | output | 1 | One-cycle request to flush address translation |

## Verification
The hardest states to reach are the supervisor aliases. Their effect depends on what is currently delegated, and a supervisor status write must keep MPP while still being able to change SUM or MXR and so trigger a flush. The stimulus interleaves random writes to the delegation register with random writes to the supervisor views. A reference model then predicts every readable register after each write. Directed writes cover the reserved privilege encoding, the F-clears-D rule and an undelegated supervisor pending write. A second, 32-bit instance with user mode absent and the extension present exercises the forced machine privilege and the bit-31 dirty summary.

// File: rtl/csr_legal_pkg.sv
package csr_legal_pkg;

    // Standard privileged CSR addresses
    localparam logic [11:0] A_SSTATUS  = 12'h100;
    localparam logic [11:0] A_SIE      = 12'h104;
    localparam logic [11:0] A_STVEC    = 12'h105;
    localparam logic [11:0] A_SIP      = 12'h144;
    localparam logic [11:0] A_MSTATUS  = 12'h300;
    localparam logic [11:0] A_MISA     = 12'h301;
    localparam logic [11:0] A_MEDELEG  = 12'h302;
    localparam logic [11:0] A_MIDELEG  = 12'h303;
    localparam logic [11:0] A_MIE      = 12'h304;
    localparam logic [11:0] A_MTVEC    = 12'h305;
    localparam logic [11:0] A_MIP      = 12'h344;

    // Status field positions
    localparam int MPP_LO = 11;
    localparam int FS_LO  = 13;
    localparam int XS_LO  = 15;

    // Status masks (64-bit, truncated per XLEN by users)
    localparam logic [63:0] ST_WMASK_BASE = 64'h0000_0000_007E_60AA;
    localparam logic [63:0] ST_XS         = 64'h0000_0000_0001_8000;
    localparam logic [63:0] ST_XLAT       = 64'h0000_0000_000E_1800;
    localparam logic [63:0] SST_WMASK     = 64'h0000_0000_000D_E122;
    localparam logic [63:0] SST_RMASK32   = 64'h0000_0000_0005_E122;
    localparam logic [63:0] XL_FIELDS64   = 64'h0000_000F_0000_0000;
    localparam logic [63:0] XL_PINNED64   = 64'h0000_000A_0000_0000;

    // Interrupt and exception masks
    localparam logic [63:0] IP_WMASK      = 64'h22;
    localparam logic [63:0] IE_WMASK      = 64'h12AA;
    localparam logic [63:0] IDELEG_MASK   = 64'h1222;
    localparam logic [63:0] EDELEG_MASK   = 64'hB109;
    localparam logic [63:0] ISA_WMASK     = 64'h102D;
    localparam int          ISA_F_BIT     = 5;
    localparam int          ISA_D_BIT     = 3;
    localparam int          SSIP_BIT      = 1;

    typedef enum logic [1:0] {
        PRIV_USER = 2'd0,
        PRIV_SUP  = 2'd1,
        PRIV_RSVD = 2'd2,
        PRIV_MACH = 2'd3
    } priv_e;

    // One strobe per implemented register (write side)
    typedef struct packed {
        logic st_m;
        logic st_s;
        logic ip_m;
        logic ip_s;
        logic ie_m;
        logic ie_s;
        logic deleg_i;
        logic deleg_e;
        logic isa;
        logic tv_m;
        logic tv_s;
    } csr_sel_t;

    function automatic priv_e legal_priv(input logic [1:0] req, input bit has_u, input bit has_s);
        if (!has_u)                            return PRIV_MACH;
        else if (req == PRIV_RSVD || !has_s)   return PRIV_USER;
        else                                   return priv_e'(req);
    endfunction

    function automatic logic ctx_dirty(input logic [1:0] fs, input logic [1:0] xs);
        return (fs == 2'b11) || (xs == 2'b11);
    endfunction

    function automatic logic [63:0] isa_reset(input int xlen, input bit has_u, input bit has_s);
        logic [63:0] v;
        v = 64'h112D;
        if (has_s) v[18] = 1'b1;
        if (has_u) v[20] = 1'b1;
        if (xlen == 64) v[63:62] = 2'd2;
        else            v[31:30] = 2'd1;
        return v;
    endfunction

endpackage

// File: rtl/csr_status_reg.sv
module csr_status_reg
    import csr_legal_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter bit HAS_U   = 1'b1,
    parameter bit HAS_S   = 1'b1,
    parameter bit HAS_EXT = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_val,
    output logic [XLEN-1:0] status_q,
    output logic            flush_q
);
    localparam logic [63:0]     WM64 = HAS_EXT ? (ST_WMASK_BASE | ST_XS) : ST_WMASK_BASE;
    localparam logic [63:0]     XM64 = (XLEN == 64) ? XL_FIELDS64 : 64'd0;
    localparam logic [63:0]     XV64 = (XLEN == 64) ? XL_PINNED64 : 64'd0;
    localparam logic [XLEN-1:0] WMASK   = WM64[XLEN-1:0];
    localparam logic [XLEN-1:0] XLMASK  = XM64[XLEN-1:0];
    localparam logic [XLEN-1:0] XLVAL   = XV64[XLEN-1:0];
    localparam logic [XLEN-1:0] XLATM   = ST_XLAT[XLEN-1:0];
    localparam int              SD_BIT  = XLEN - 1;

    logic [XLEN-1:0] nxt;
    logic            flush_d;

    always_comb begin
        nxt = (status_q & ~WMASK) | (wr_val & WMASK);
        nxt[MPP_LO+1:MPP_LO] = legal_priv(wr_val[MPP_LO+1:MPP_LO], HAS_U, HAS_S);
        nxt = (nxt & ~XLMASK) | XLVAL;
        nxt[SD_BIT] = ctx_dirty(nxt[FS_LO+1:FS_LO], nxt[XS_LO+1:XS_LO]);
        flush_d = wr_en && (((nxt ^ status_q) & XLATM) != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= XLVAL;
            flush_q  <= 1'b0;
        end else begin
            flush_q <= flush_d;
            if (wr_en) status_q <= nxt;
        end
    end

    assert_sd_summary_R4: assert property (@(posedge clk) disable iff (rst)
        status_q[SD_BIT] == ((status_q[FS_LO+1:FS_LO] == 2'b11) || (status_q[XS_LO+1:XS_LO] == 2'b11)));

    assert_mpp_never_rsvd_R3: assert property (@(posedge clk) disable iff (rst)
        status_q[MPP_LO+1:MPP_LO] != PRIV_RSVD);

    assert_xl_pinned_R5: assert property (@(posedge clk) disable iff (rst)
        (status_q & XLMASK) == XLVAL);

    assert_flush_after_write_R6: assert property (@(posedge clk) disable iff (rst)
        flush_q |-> $past(wr_en));

    assert_spp_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        $stable(status_q[8]));
endmodule

// File: rtl/csr_irq_regs.sv
module csr_irq_regs
    import csr_legal_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  csr_sel_t        sel,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] mip_q,
    output logic [XLEN-1:0] mie_q,
    output logic [XLEN-1:0] ideleg_q,
    output logic [XLEN-1:0] edeleg_q
);
    localparam logic [XLEN-1:0] IPM = IP_WMASK[XLEN-1:0];
    localparam logic [XLEN-1:0] IEM = IE_WMASK[XLEN-1:0];
    localparam logic [XLEN-1:0] IDM = IDELEG_MASK[XLEN-1:0];
    localparam logic [XLEN-1:0] EDM = EDELEG_MASK[XLEN-1:0];

    logic [XLEN-1:0] ip_src, ie_src, ssip_only;

    always_comb begin
        ssip_only           = '0;
        ssip_only[SSIP_BIT] = ideleg_q[SSIP_BIT];
        ip_src = sel.ip_s ? ((mip_q & ~ssip_only) | (wdata & ssip_only)) : wdata;
        ie_src = sel.ie_s ? ((mie_q & ~ideleg_q) | (wdata & ideleg_q)) : wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mip_q    <= '0;
            mie_q    <= '0;
            ideleg_q <= '0;
            edeleg_q <= '0;
        end else begin
            if (sel.ip_m || sel.ip_s) mip_q    <= (mip_q & ~IPM) | (ip_src & IPM);
            if (sel.ie_m || sel.ie_s) mie_q    <= (mie_q & ~IEM) | (ie_src & IEM);
            if (sel.deleg_i)          ideleg_q <= (ideleg_q & ~IDM) | (wdata & IDM);
            if (sel.deleg_e)          edeleg_q <= (edeleg_q & ~EDM) | (wdata & EDM);
        end
    end

    assert_ip_mask_R7: assert property (@(posedge clk) disable iff (rst)
        (mip_q & ~IPM) == '0);
    assert_ie_mask_R7: assert property (@(posedge clk) disable iff (rst)
        (mie_q & ~IEM) == '0);
    assert_ideleg_mask_R7: assert property (@(posedge clk) disable iff (rst)
        (ideleg_q & ~IDM) == '0);
    assert_edeleg_mask_R8: assert property (@(posedge clk) disable iff (rst)
        (edeleg_q & ~EDM) == '0);
    assert_sip_undelegated_R10: assert property (@(posedge clk) disable iff (rst)
        (sel.ip_s && !ideleg_q[SSIP_BIT]) |=> $stable(mip_q));
endmodule

// File: rtl/csr_isa_vec.sv
module csr_isa_vec
    import csr_legal_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter bit HAS_U = 1'b1,
    parameter bit HAS_S = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  csr_sel_t        sel,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] misa_q,
    output logic [XLEN-1:0] mtvec_q,
    output logic [XLEN-1:0] stvec_q
);
    localparam logic [63:0]     ISA_RST64 = isa_reset(XLEN, HAS_U, HAS_S);
    localparam logic [XLEN-1:0] ISA_RST   = ISA_RST64[XLEN-1:0];
    localparam logic [XLEN-1:0] ISAM      = ISA_WMASK[XLEN-1:0];

    logic [XLEN-1:0] isa_src;

    always_comb begin
        isa_src = wdata;
        if (!wdata[ISA_F_BIT]) isa_src[ISA_D_BIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            misa_q  <= ISA_RST;
            mtvec_q <= '0;
            stvec_q <= '0;
        end else begin
            if (sel.isa)  misa_q  <= (misa_q & ~ISAM) | (isa_src & ISAM);
            if (sel.tv_m) mtvec_q <= {wdata[XLEN-1:2], 1'b0, wdata[0]};
            if (sel.tv_s) stvec_q <= {wdata[XLEN-1:2], 2'b00};
        end
    end

    assert_stvec_align_R11: assert property (@(posedge clk) disable iff (rst)
        stvec_q[1:0] == 2'b00);
    assert_mtvec_bit1_R11: assert property (@(posedge clk) disable iff (rst)
        !mtvec_q[1]);
    assert_mxl_fixed_R12: assert property (@(posedge clk) disable iff (rst)
        $stable(misa_q[XLEN-1:XLEN-2]));
    assert_f_clears_d_R12: assert property (@(posedge clk) disable iff (rst)
        (sel.isa && !wdata[ISA_F_BIT]) |=> !misa_q[ISA_D_BIT]);
endmodule

// File: rtl/csr_legalizer.sv
module csr_legalizer
    import csr_legal_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter bit HAS_U   = 1'b1,
    parameter bit HAS_S   = 1'b1,
    parameter bit HAS_EXT = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic            csr_we,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_illegal,
    output logic            xlat_flush
);
    localparam logic [63:0]     SRM64 = (XLEN == 64) ? (SST_RMASK32 | 64'h3_0000_0000) : SST_RMASK32;
    localparam logic [XLEN-1:0] SRMASK = SRM64[XLEN-1:0];
    localparam logic [XLEN-1:0] SWMASK = SST_WMASK[XLEN-1:0];
    localparam logic [XLEN-1:0] SDMASK = {1'b1, {(XLEN-1){1'b0}}};

    csr_sel_t        hit, wsel;
    logic [XLEN-1:0] status_q, mip_q, mie_q, ideleg_q, edeleg_q;
    logic [XLEN-1:0] misa_q, mtvec_q, stvec_q, st_wval;

    always_comb begin
        hit = '0;
        unique case (csr_addr)
            A_MSTATUS: hit.st_m    = 1'b1;
            A_SSTATUS: hit.st_s    = 1'b1;
            A_MIP:     hit.ip_m    = 1'b1;
            A_SIP:     hit.ip_s    = 1'b1;
            A_MIE:     hit.ie_m    = 1'b1;
            A_SIE:     hit.ie_s    = 1'b1;
            A_MIDELEG: hit.deleg_i = 1'b1;
            A_MEDELEG: hit.deleg_e = 1'b1;
            A_MISA:    hit.isa     = 1'b1;
            A_MTVEC:   hit.tv_m    = 1'b1;
            A_STVEC:   hit.tv_s    = 1'b1;
            default:   hit         = '0;
        endcase
        wsel        = csr_we ? hit : '0;
        csr_illegal = (hit == '0);
        st_wval     = hit.st_s ? ((status_q & ~SWMASK) | (csr_wdata & SWMASK)) : csr_wdata;
    end

    always_comb begin
        csr_rdata = '0;
        if (hit.st_m)    csr_rdata = status_q;
        if (hit.st_s)    csr_rdata = (status_q & SRMASK) | (status_q & SDMASK);
        if (hit.ip_m)    csr_rdata = mip_q;
        if (hit.ip_s)    csr_rdata = mip_q & ideleg_q;
        if (hit.ie_m)    csr_rdata = mie_q;
        if (hit.ie_s)    csr_rdata = mie_q & ideleg_q;
        if (hit.deleg_i) csr_rdata = ideleg_q;
        if (hit.deleg_e) csr_rdata = edeleg_q;
        if (hit.isa)     csr_rdata = misa_q;
        if (hit.tv_m)    csr_rdata = mtvec_q;
        if (hit.tv_s)    csr_rdata = stvec_q;
    end

    csr_status_reg #(.XLEN(XLEN), .HAS_U(HAS_U), .HAS_S(HAS_S), .HAS_EXT(HAS_EXT)) u_status (
        .clk(clk), .rst(rst),
        .wr_en(wsel.st_m || wsel.st_s), .wr_val(st_wval),
        .status_q(status_q), .flush_q(xlat_flush)
    );

    csr_irq_regs #(.XLEN(XLEN)) u_irq (
        .clk(clk), .rst(rst), .sel(wsel), .wdata(csr_wdata),
        .mip_q(mip_q), .mie_q(mie_q), .ideleg_q(ideleg_q), .edeleg_q(edeleg_q)
    );

    csr_isa_vec #(.XLEN(XLEN), .HAS_U(HAS_U), .HAS_S(HAS_S)) u_isa (
        .clk(clk), .rst(rst), .sel(wsel), .wdata(csr_wdata),
        .misa_q(misa_q), .mtvec_q(mtvec_q), .stvec_q(stvec_q)
    );

    assert_illegal_reads_zero_R13: assert property (@(posedge clk) disable iff (rst)
        csr_illegal |-> (csr_rdata == '0));
    assert_onehot_decode_R13: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));
    assert_sstatus_keeps_mpp_R9: assert property (@(posedge clk) disable iff (rst)
        (csr_we && hit.st_s) |=> $stable(status_q[MPP_LO+1:MPP_LO]));
endmodule

// File: tb/csr_legalizer_tb.sv
module csr_legalizer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = '0, addr2 = '0;
    logic [63:0] wdata = '0;
    logic [31:0] wdata2 = '0;
    logic        we = 1'b0, we2 = 1'b0;
    logic [63:0] rdata;
    logic [31:0] rdata2;
    logic        illegal, illegal2, flush, flush2;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csr_legalizer u_dut (
        .clk(clk), .rst(rst), .csr_addr(addr), .csr_wdata(wdata), .csr_we(we),
        .csr_rdata(rdata), .csr_illegal(illegal), .xlat_flush(flush)
    );

    csr_legalizer #(.XLEN(32), .HAS_U(1'b0), .HAS_S(1'b1), .HAS_EXT(1'b1)) u_dut32 (
        .clk(clk), .rst(rst), .csr_addr(addr2), .csr_wdata(wdata2), .csr_we(we2),
        .csr_rdata(rdata2), .csr_illegal(illegal2), .xlat_flush(flush2)
    );

    // Reference model of the 64-bit instance
    logic [63:0] m_st, m_ip, m_ie, m_id, m_ed, m_isa, m_mtv, m_stv;

    localparam logic [11:0] ADDRS [12] = '{12'h100, 12'h104, 12'h105, 12'h144, 12'h300, 12'h301,
                                           12'h302, 12'h303, 12'h304, 12'h305, 12'h344, 12'h7C0};

    function automatic string req_of(input logic [11:0] a);
        case (a)
            12'h300:                   return "R2";
            12'h100:                   return "R9";
            12'h344, 12'h304, 12'h303: return "R7";
            12'h302:                   return "R8";
            12'h144, 12'h104:          return "R10";
            12'h305, 12'h105:          return "R11";
            12'h301:                   return "R12";
            default:                   return "R13";
        endcase
    endfunction

    function automatic logic [63:0] st_apply(input logic [63:0] old, input logic [63:0] v);
        logic [63:0] n;
        logic [1:0]  p;
        n = (old & ~64'h7E60AA) | (v & 64'h7E60AA);
        p = v[12:11];
        if (p == 2'd2) p = 2'd0;
        n[12:11] = p;
        n[35:32] = 4'b1010;
        n[63] = (n[14:13] == 2'b11) || (n[16:15] == 2'b11);
        return n;
    endfunction

    function automatic logic [64:0] exp_read(input logic [11:0] a);
        case (a)
            12'h300: return {1'b1, m_st};
            12'h100: return {1'b1, (m_st & 64'h3_0005_E122) | (m_st & 64'h8000_0000_0000_0000)};
            12'h344: return {1'b1, m_ip};
            12'h144: return {1'b1, m_ip & m_id};
            12'h304: return {1'b1, m_ie};
            12'h104: return {1'b1, m_ie & m_id};
            12'h303: return {1'b1, m_id};
            12'h302: return {1'b1, m_ed};
            12'h301: return {1'b1, m_isa};
            12'h305: return {1'b1, m_mtv};
            12'h105: return {1'b1, m_stv};
            default: return {1'b0, 64'd0};
        endcase
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [63:0] v, output logic fl);
        logic [63:0] n, m;
        fl = 1'b0;
        case (a)
            12'h300: begin n = st_apply(m_st, v); fl = ((n ^ m_st) & 64'hE1800) != 0; m_st = n; end
            12'h100: begin
                n = st_apply(m_st, (m_st & ~64'hDE122) | (v & 64'hDE122));
                fl = ((n ^ m_st) & 64'hE1800) != 0; m_st = n;
            end
            12'h344: m_ip = (m_ip & ~64'h22) | (v & 64'h22);
            12'h144: begin m = 64'h2 & m_id; m_ip = (m_ip & ~m) | (v & m); end
            12'h304: m_ie = (m_ie & ~64'h12AA) | (v & 64'h12AA);
            12'h104: begin n = (m_ie & ~m_id) | (v & m_id); m_ie = (m_ie & ~64'h12AA) | (n & 64'h12AA); end
            12'h303: m_id = v & 64'h1222;
            12'h302: m_ed = v & 64'hB109;
            12'h301: begin n = v; if (!v[5]) n[3] = 1'b0; m_isa = (m_isa & ~64'h102D) | (n & 64'h102D); end
            12'h305: m_mtv = v & ~64'h2;
            12'h105: m_stv = v & ~64'h3;
            default: ;
        endcase
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [63:0] v);
        logic fl;
        @(negedge clk);
        addr = a; wdata = v; we = 1'b1;
        model_write(a, v, fl);
        @(posedge clk); #1;
        we = 1'b0;
        chk("R6 flush pulse", {63'd0, flush}, {63'd0, fl});
        @(posedge clk); #1;
        chk("R6 flush one cycle", {63'd0, flush}, 64'd0);
    endtask

    task automatic check_all();
        logic [64:0] e;
        foreach (ADDRS[i]) begin
            @(negedge clk);
            addr = ADDRS[i];
            #1;
            e = exp_read(ADDRS[i]);
            chk(req_of(ADDRS[i]), rdata, e[63:0]);
            chk({req_of(ADDRS[i]), " illegal flag"}, {63'd0, illegal}, {63'd0, ~e[64]});
        end
    endtask

    task automatic w32(input logic [11:0] a, input logic [31:0] v, input logic exp_fl);
        @(negedge clk);
        addr2 = a; wdata2 = v; we2 = 1'b1;
        @(posedge clk); #1;
        we2 = 1'b0;
        chk("R6 flush (32-bit)", {63'd0, flush2}, {63'd0, exp_fl});
    endtask

    task automatic r32(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr2 = a;
        #1;
        chk(req, {32'd0, rdata2}, {32'd0, exp});
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_st = 64'hA_0000_0000; m_ip = '0; m_ie = '0; m_id = '0; m_ed = '0;
        m_isa = 64'h8000_0000_0014_112D; m_mtv = '0; m_stv = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state of every register, including pinned UXL/SXL (R5)
        check_all();
        r32("R1 status 32-bit reset", 12'h300, 32'h0);
        r32("R1 isa 32-bit reset", 12'h301, 32'h4004_112D);

        // R2/R3/R4/R5: all-ones status write
        do_write(12'h300, '1);
        check_all();
        // R3: reserved encoding 2 becomes user
        do_write(12'h300, 64'h1000);
        @(negedge clk); addr = 12'h300; #1;
        chk("R3 MPP reserved->user", {62'd0, rdata[12:11]}, 64'd0);
        // R6: same write again changes nothing
        do_write(12'h300, 64'h1000);
        // R9/R6: supervisor status write flips SUM and MXR
        do_write(12'h100, 64'hC_0000);
        check_all();
        // R10: undelegated supervisor pending write is ignored
        do_write(12'h303, 64'h0);
        do_write(12'h144, 64'h2);
        @(negedge clk); addr = 12'h344; #1;
        chk("R10 sip write undelegated", rdata, 64'h0);
        do_write(12'h303, '1);
        do_write(12'h144, '1);
        @(negedge clk); addr = 12'h344; #1;
        chk("R10 sip write delegated", rdata, 64'h2);
        // R13: unimplemented address
        do_write(12'h7C0, '1);
        check_all();
        // R12: F clear forces D clear
        do_write(12'h301, 64'h8);
        @(negedge clk); addr = 12'h301; #1;
        chk("R12 D cleared without F", {63'd0, rdata[3]}, 64'd0);
        // R11: trap vectors with all ones
        do_write(12'h305, '1);
        do_write(12'h105, '1);
        check_all();

        // Random mix
        for (int it = 0; it < 400; it++) begin
            logic [11:0] a;
            logic [63:0] v;
            a = ADDRS[$urandom_range(0, 11)];
            v = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) v = v & 64'hFF_FFFF;
            do_write(a, v);
            check_all();
        end

        // 32-bit instance, no user mode, extension present
        w32(12'h300, 32'h0, 1'b1);
        r32("R3 MPP forced to machine", 12'h300, 32'h0000_1800);
        w32(12'h300, 32'h0000_6000, 1'b0);
        r32("R4 dirty from FS at bit 31", 12'h300, 32'h8000_7800);
        w32(12'h300, 32'h0001_8000, 1'b0);
        r32("R4 dirty from XS with extension (R2)", 12'h300, 32'h8001_9800);
        r32("R9 sstatus view 32-bit", 12'h100, 32'h8001_8000);
        w32(12'h300, 32'h0, 1'b0);
        r32("R4 dirty clears", 12'h300, 32'h0000_1800);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule